// File: doc/BRIEF.md
# Masked Vector Lane Execution Unit

This block is one integer lane of a vector pipeline. After a start request it reads one 64-bit element per clock for as many elements as the vector length register holds. It adds or subtracts two vector operands, or a vector operand and a scalar, and returns each result with its element index and a write enable. A compare operation checks every element against a scalar and records the outcome in a per-element mask register. When masked execution is selected, later arithmetic operations use that mask to suppress writes.

The surrounding datapath supplies the operands. It watches `issue_active` and `issue_idx` and drives element `issue_idx` of each source in that cycle. It takes `res_we`, `res_idx` and `res_data` to write the destination register. The vector length is loaded at any time through `vl_wr`. The value in the register when `start` is accepted governs that operation.

Top module: `vlane_unit`

## Requirements
- R1: After reset, `mask_q` is all ones, `vl_q` is 64, and `busy`, `issue_active`, `res_we` and `done` are 0.
- R2: A write through `vl_wr` stores `vl_wdata`, clamped to the range 1 to 64. A 0 stores 1, and any value above 64 stores 64.
- R3: Op code 0 (vector plus vector) returns a+b modulo 2^64. The result for the element presented in cycle c appears on `res_data` in cycle c+6, with `res_idx` equal to that element's index.
- R4: Op code 1 returns a-b, op code 2 returns a+scalar and op code 3 returns a-scalar, all modulo 2^64 and with the same timing as R3.
- R5: Op code 4 sets mask bit i to 1 when element a_i differs from `scalar`, and clears it otherwise, for every i below the vector length. It leaves mask bits at and above the vector length unchanged. It asserts no `res_we`, and it ignores `mask_en`.
- R6: With `mask_en`=1 at start, an arithmetic element whose mask bit is 0 produces no `res_we`. With `mask_en`=0, every element below the vector length is written.
- R7: When `start` is accepted in cycle s, `issue_active` is high in exactly cycles s+1 to s+VL, and `issue_idx` counts 0 to VL-1. No result is written for an index at or above VL.
- R8: `done` is high for exactly one cycle, in cycle s+VL+7, which is the cycle after the last result leaves the pipeline.
- R9: `start` is ignored while `busy` is high. A start pulse during an operation does not change the element count, the results or the mask.
- R10: Op codes 5 to 7 write no results and leave the mask unchanged. They still issue VL elements and raise `done` at s+VL+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vl_wr | input | 1 | Load the vector length register |
| vl_wdata | input | 7 | New vector length (clamped to 1..64) |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 3 | Operation code, sampled with start |
| mask_en | input | 1 | Masked execution select, sampled with start |
| a_elem | input | 64 | First vector operand, element issue_idx |
| b_elem | input | 64 | Second vector operand, element issue_idx |
| scalar | input | 64 | Scalar operand for vector-scalar ops and compare |
| issue_active | output | 1 | An element is being consumed this cycle |
| issue_idx | output | 6 | Index of the element being consumed |
| busy | output | 1 | Operation in progress |
| res_we | output | 1 | Result element write enable |
| res_idx | output | 6 | Destination element index |
| res_data | output | 64 | Result element |
| done | output | 1 | One-cycle completion pulse |
| mask_q | output | 64 | Mask register contents |
| vl_q | output | 7 | Vector length register contents |

## Verification
Arithmetic is run at full length with operands whose upper and lower halves move independently. This exposes carry errors and swapped operand sources. Short lengths with a subtrahend larger than the minuend check wrap-around and the end of the element stream. The compare is run on a pattern in which every third element equals the scalar. It is then run again at length 5 over a known mask, which separates correct per-index mask writes from writes that spill past the length. A masked add and an unmasked add over the same mask show whether the mask-enable choice is honoured. Each run also checks the cycle of every result and of `done`.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

   typedef enum logic [2:0] {
      VOP_ADD_VV = 3'd0,
      VOP_SUB_VV = 3'd1,
      VOP_ADD_VS = 3'd2,
      VOP_SUB_VS = 3'd3,
      VOP_CMP_NE = 3'd4
   } vop_e;

   function automatic logic vop_is_arith(input logic [2:0] code);
      return (code <= 3'd3);
   endfunction

   function automatic logic vop_uses_scalar(input logic [2:0] code);
      return (code == VOP_ADD_VS) || (code == VOP_SUB_VS);
   endfunction

   function automatic logic vop_is_sub(input logic [2:0] code);
      return (code == VOP_SUB_VV) || (code == VOP_SUB_VS);
   endfunction

endpackage

// File: rtl/vlane_vl_reg.sv
module vlane_vl_reg #(
   parameter int MAX_VL = 64,
   parameter int VL_W   = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [VL_W-1:0] wdata,
   output logic [VL_W-1:0] vl
);
   localparam logic [VL_W-1:0] VL_MAX = VL_W'(MAX_VL);

   logic [VL_W-1:0] clamped;

   always_comb begin
      if (wdata == '0)          clamped = VL_W'(1);
      else if (wdata > VL_MAX)  clamped = VL_MAX;
      else                      clamped = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vl <= VL_MAX;
      else if (wr)  vl <= clamped;
   end
endmodule

// File: rtl/vlane_issue.sv
module vlane_issue #(
   parameter int IDX_W = 6,
   parameter int VL_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [VL_W-1:0]  vl,
   output logic             active,
   output logic             last,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] len_m1;

   assign last = active && (idx == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         len_m1 <= '0;
      end else if (accept) begin
         active <= 1'b1;
         idx    <= '0;
         len_m1 <= IDX_W'(vl - VL_W'(1));
      end else if (active) begin
         if (last) active <= 1'b0;
         else      idx    <= idx + IDX_W'(1);
      end
   end
endmodule

// File: rtl/vlane_pipe.sv
module vlane_pipe #(
   parameter int ELEM_W = 64,
   parameter int IDX_W  = 6,
   parameter int LAT    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic              in_wr,
   input  logic              in_cmp,
   input  logic              in_bit,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [ELEM_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_last,
   output logic              out_wr,
   output logic              out_cmp,
   output logic              out_bit,
   output logic [IDX_W-1:0]  out_idx,
   output logic [ELEM_W-1:0] out_data,
   output logic              any_valid
);
   logic [LAT-1:0]    st_v, st_l, st_w, st_c, st_b;
   logic [IDX_W-1:0]  st_i [LAT];
   logic [ELEM_W-1:0] st_d [LAT];

   for (genvar k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[0] <= 1'b0; st_l[0] <= 1'b0; st_w[0] <= 1'b0;
               st_c[0] <= 1'b0; st_b[0] <= 1'b0;
               st_i[0] <= '0;   st_d[0] <= '0;
            end else begin
               st_v[0] <= in_valid;
               st_l[0] <= in_valid & in_last;
               st_w[0] <= in_valid & in_wr;
               st_c[0] <= in_valid & in_cmp;
               st_b[0] <= in_bit;
               st_i[0] <= in_idx;
               st_d[0] <= in_data;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[k] <= 1'b0; st_l[k] <= 1'b0; st_w[k] <= 1'b0;
               st_c[k] <= 1'b0; st_b[k] <= 1'b0;
               st_i[k] <= '0;   st_d[k] <= '0;
            end else begin
               st_v[k] <= st_v[k-1];
               st_l[k] <= st_l[k-1];
               st_w[k] <= st_w[k-1];
               st_c[k] <= st_c[k-1];
               st_b[k] <= st_b[k-1];
               st_i[k] <= st_i[k-1];
               st_d[k] <= st_d[k-1];
            end
         end
      end
   end

   assign out_valid = st_v[LAT-1];
   assign out_last  = st_l[LAT-1];
   assign out_wr    = st_w[LAT-1];
   assign out_cmp   = st_c[LAT-1];
   assign out_bit   = st_b[LAT-1];
   assign out_idx   = st_i[LAT-1];
   assign out_data  = st_d[LAT-1];
   assign any_valid = |st_v;
endmodule

// File: rtl/vlane_mask_reg.sv
module vlane_mask_reg #(
   parameter int MAX_VL = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit,
   output logic [MAX_VL-1:0] mask
);
   for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               mask[i] <= 1'b1;
         else if (wr && (wr_idx == IDX_W'(i)))     mask[i] <= wr_bit;
      end
   end
endmodule

// File: rtl/vlane_unit.sv
module vlane_unit
   import vlane_pkg::*;
#(
   parameter int ELEM_W  = 64,
   parameter int MAX_VL  = 64,
   parameter int ADD_LAT = 6,
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int VL_W   = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vl_wr,
   input  logic [VL_W-1:0]   vl_wdata,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              mask_en,
   input  logic [ELEM_W-1:0] a_elem,
   input  logic [ELEM_W-1:0] b_elem,
   input  logic [ELEM_W-1:0] scalar,
   output logic              issue_active,
   output logic [IDX_W-1:0]  issue_idx,
   output logic              busy,
   output logic              res_we,
   output logic [IDX_W-1:0]  res_idx,
   output logic [ELEM_W-1:0] res_data,
   output logic              done,
   output logic [MAX_VL-1:0] mask_q,
   output logic [VL_W-1:0]   vl_q
);
   if (ELEM_W < 1) begin : g_bad_width
      $error("vlane_unit: ELEM_W must be positive");
   end
   if (MAX_VL < 2 || (MAX_VL & (MAX_VL - 1)) != 0) begin : g_bad_len
      $error("vlane_unit: MAX_VL must be a power of two of at least 2");
   end
   if (ADD_LAT < 1) begin : g_bad_lat
      $error("vlane_unit: ADD_LAT must be at least 1");
   end

   logic              accept;
   logic              issue_last;
   logic [2:0]        op_q;
   logic              mask_en_q;
   logic              pipe_busy;
   logic              done_q;
   logic [ELEM_W-1:0] rhs;
   logic [ELEM_W-1:0] alu_out;
   logic              elem_wr;
   logic              cmp_ne;
   logic              p_valid, p_last, p_wr, p_cmp, p_bit;
   logic [IDX_W-1:0]  p_idx;
   logic [ELEM_W-1:0] p_data;

   assign busy   = issue_active | pipe_busy | done_q;
   assign accept = start & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= 3'd0;
         mask_en_q <= 1'b0;
      end else if (accept) begin
         op_q      <= op;
         mask_en_q <= mask_en;
      end
   end

   vlane_vl_reg #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_vl (
      .clk(clk), .rst_n(rst_n), .wr(vl_wr), .wdata(vl_wdata), .vl(vl_q)
   );

   vlane_issue #(.IDX_W(IDX_W), .VL_W(VL_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .accept(accept), .vl(vl_q),
      .active(issue_active), .last(issue_last), .idx(issue_idx)
   );

   always_comb begin
      rhs     = vop_uses_scalar(op_q) ? scalar : b_elem;
      alu_out = vop_is_sub(op_q) ? (a_elem - rhs) : (a_elem + rhs);
      cmp_ne  = (a_elem != scalar);
      elem_wr = vop_is_arith(op_q) && (!mask_en_q || mask_q[issue_idx]);
   end

   vlane_pipe #(.ELEM_W(ELEM_W), .IDX_W(IDX_W), .LAT(ADD_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_valid(issue_active), .in_last(issue_last), .in_wr(elem_wr),
      .in_cmp(op_q == VOP_CMP_NE), .in_bit(cmp_ne), .in_idx(issue_idx),
      .in_data(alu_out),
      .out_valid(p_valid), .out_last(p_last), .out_wr(p_wr), .out_cmp(p_cmp),
      .out_bit(p_bit), .out_idx(p_idx), .out_data(p_data), .any_valid(pipe_busy)
   );

   vlane_mask_reg #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(p_valid & p_cmp), .wr_idx(p_idx),
      .wr_bit(p_bit), .mask(mask_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= p_valid & p_last;
   end

   assign res_we   = p_valid & p_wr;
   assign res_idx  = p_idx;
   assign res_data = p_data;
   assign done     = done_q;
endmodule

// File: rtl/vlane_unit_chk.sv
module vlane_unit_chk #(
   parameter int MAX_VL = 64,
   parameter int IDX_W  = 6,
   parameter int VL_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              issue_active,
   input logic [IDX_W-1:0]  issue_idx,
   input logic              res_we,
   input logic [IDX_W-1:0]  res_idx,
   input logic              done,
   input logic [MAX_VL-1:0] mask_q,
   input logic [VL_W-1:0]   vl_q
);
   logic [VL_W-1:0] len_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              len_c <= VL_W'(MAX_VL);
      else if (start && !busy) len_c <= vl_q;
   end

   assert_vl_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vl_q >= VL_W'(1)) && (vl_q <= VL_W'(MAX_VL)));

   assert_issue_below_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_active |-> (VL_W'(issue_idx) < len_c));

   assert_write_below_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> (VL_W'(res_idx) < len_c));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!issue_active && !res_we));

   assert_mask_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(mask_q));

   assert_start_when_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> !(issue_active && issue_idx == '0));
endmodule

bind vlane_unit vlane_unit_chk #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .issue_active(issue_active), .issue_idx(issue_idx), .res_we(res_we),
   .res_idx(res_idx), .done(done), .mask_q(mask_q), .vl_q(vl_q)
);

// File: tb/vlane_unit_bench.sv
module vlane_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vl_wr = 1'b0;
   logic [6:0]  vl_wdata = '0;
   logic        start = 1'b0;
   logic [2:0]  op = '0;
   logic        mask_en = 1'b0;
   logic [63:0] a_elem = '0, b_elem = '0, scalar = '0;
   logic        issue_active, busy, res_we, done;
   logic [5:0]  issue_idx, res_idx;
   logic [63:0] res_data, mask_q;
   logic [6:0]  vl_q;

   always #4 clk = ~clk;

   vlane_unit u_vlane_unit (
      .clk(clk), .rst_n(rst_n), .vl_wr(vl_wr), .vl_wdata(vl_wdata),
      .start(start), .op(op), .mask_en(mask_en), .a_elem(a_elem),
      .b_elem(b_elem), .scalar(scalar), .issue_active(issue_active),
      .issue_idx(issue_idx), .busy(busy), .res_we(res_we), .res_idx(res_idx),
      .res_data(res_data), .done(done), .mask_q(mask_q), .vl_q(vl_q)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   bit finished = 1'b0;
   logic [63:0] A [64], B [64];
   logic [63:0] mask_m = '1;
   int          vl_m = 64;
   bit          got_we [64];
   logic [63:0] got_d [64];
   int          got_cyc [64];
   int          nwr, ndone, done_cyc, niss;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (res_we) begin
         got_we[res_idx]  = 1'b1;
         got_d[res_idx]   = res_data;
         got_cyc[res_idx] = cyc;
         nwr++;
      end
      if (done) begin ndone++; done_cyc = cyc; end
      if (issue_active) niss++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      for (int i = 0; i < 64; i++) begin
         got_we[i] = 1'b0; got_d[i] = '0; got_cyc[i] = -1;
      end
      nwr = 0; ndone = 0; done_cyc = -1; niss = 0;
   endtask

   task automatic write_vl(input logic [6:0] v);
      @(negedge clk);
      vl_wr = 1'b1; vl_wdata = v;
      @(negedge clk);
      vl_wr = 1'b0;
      vl_m = (v == 0) ? 1 : ((v > 64) ? 64 : int'(v));
   endtask

   // Runs one operation, driving element i in the issue cycle s+1+i, and
   // checks results, timing and mask against the bench model.
   task automatic run_op(input logic [2:0] code, input bit me, input string req,
                         input int inject_at);
      int s;
      logic [63:0] exp_mask, rhs, exp_d;
      bit exp_we;
      clear_log();
      exp_mask = mask_m;
      @(negedge clk);
      s = cyc;
      start = 1'b1; op = code; mask_en = me;
      for (int i = 0; i < vl_m; i++) begin
         @(negedge clk);
         start = (i == inject_at);
         op = (i == inject_at) ? 3'd4 : code;
         a_elem = A[i]; b_elem = B[i];
         chk(issue_active && issue_idx == 6'(i), "R7", "issue index",
             {57'd0, issue_active, issue_idx}, {57'd1, 1'b1, 6'(i)});
      end
      @(negedge clk);
      start = 1'b0;
      chk(!issue_active, "R7", "issue ends after VL", 64'(issue_active), 64'd0);
      for (int k = 0; k < 20 && ndone == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(ndone == 1, "R8", "done pulse count", 64'(ndone), 64'd1);
      chk(done_cyc == s + vl_m + 7, "R8", "done cycle",
          64'(done_cyc - s), 64'(vl_m + 7));
      chk(niss == vl_m, "R7", "issued element count", 64'(niss), 64'(vl_m));
      for (int i = 0; i < 64; i++) begin
         rhs    = (code == 3'd2 || code == 3'd3) ? scalar : B[i];
         exp_d  = (code == 3'd1 || code == 3'd3) ? A[i] - rhs : A[i] + rhs;
         exp_we = (i < vl_m) && (code <= 3'd3) && (!me || mask_m[i]);
         if (code == 3'd4 && i < vl_m) exp_mask[i] = (A[i] != scalar);
         chk(got_we[i] == exp_we, req, $sformatf("write enable [%0d]", i),
             64'(got_we[i]), 64'(exp_we));
         if (exp_we) begin
            chk(got_d[i] == exp_d, req, $sformatf("data [%0d]", i), got_d[i], exp_d);
            chk(got_cyc[i] == s + 7 + i, "R3", $sformatf("latency [%0d]", i),
                64'(got_cyc[i] - s), 64'(7 + i));
         end
      end
      mask_m = exp_mask;
      chk(mask_q == mask_m, req, "mask contents", mask_q, mask_m);
   endtask

   task automatic t_reset();
      chk(mask_q == '1, "R1", "mask after reset", mask_q, '1);
      chk(vl_q == 7'd64, "R1", "VL after reset", 64'(vl_q), 64'd64);
      chk(!busy && !issue_active && !res_we && !done, "R1", "idle outputs",
          {60'd0, busy, issue_active, res_we, done}, 64'd0);
   endtask

   task automatic t_vl_writes();
      write_vl(7'd0);
      chk(vl_q == 7'd1, "R2", "VL write 0", 64'(vl_q), 64'd1);
      write_vl(7'd100);
      chk(vl_q == 7'd64, "R2", "VL write 100", 64'(vl_q), 64'd64);
      write_vl(7'd10);
      chk(vl_q == 7'd10, "R2", "VL write 10", 64'(vl_q), 64'd10);
      write_vl(7'd64);
   endtask

   task automatic fill(input int seed);
      for (int i = 0; i < 64; i++) begin
         A[i] = {32'hA5A5_0000 + 32'(i * seed), 32'hFFFF_FFF0 + 32'(i)};
         B[i] = {32'h0F0F_0000 ^ 32'(i * 77), 32'h0000_0020 + 32'(seed)};
      end
   endtask

   initial begin
      scalar = 64'h1234_5678_9ABC_DEF0;
      clear_log();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vl_writes();

      fill(3);
      run_op(3'd0, 1'b0, "R3", -1);

      for (int i = 0; i < 64; i++) if (i % 3 == 0) A[i] = scalar;
      run_op(3'd4, 1'b0, "R5", -1);

      fill(5);
      run_op(3'd0, 1'b1, "R6", -1);
      run_op(3'd0, 1'b0, "R6", -1);

      write_vl(7'd10);
      fill(7);
      for (int i = 0; i < 64; i++) B[i] = A[i] + 64'd1;
      run_op(3'd1, 1'b0, "R4", -1);
      fill(9);
      run_op(3'd2, 1'b0, "R4", -1);
      scalar = 64'hFFFF_FFFF_FFFF_FFFF;
      run_op(3'd3, 1'b0, "R4", -1);

      write_vl(7'd5);
      for (int i = 0; i < 64; i++) A[i] = (i == 2) ? scalar : 64'(i + 3);
      run_op(3'd4, 1'b1, "R5", -1);

      write_vl(7'd12);
      fill(11);
      run_op(3'd0, 1'b0, "R9", 3);

      run_op(3'd6, 1'b0, "R10", -1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog run did not complete act=0 exp=1");
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end
endmodule